// File: doc/BRIEF.md
# Dual Q-Channel Low-Power Controller

This block runs two independent clock-quiescence handshakes for a DRAM memory controller. One handshake covers the controller's main clock and the other covers the register-bus (APB) clock. An external power controller drives the request line of each handshake. The block answers by accepting the request, which tells the power controller that the clock may be stopped, or by refusing it.

On the main clock, the block accepts a request only after the DRAM sequencer confirms that the memory is in self-refresh. It refuses every request while the gear-down configuration bit is set. On the register-bus clock, the block never refuses a request, but it holds back acceptance until the bus has no transfer in flight.

Each side raises the other side's activity flag. Pending memory traffic, or a main-clock restart in progress, wakes the register-bus clock. A busy register bus wakes the main clock. All request inputs pass through multi-flop synchronisers into the clock domain of their own channel. Both channels use active-high synchronous resets.

Top module: `dual_qchan_lp_ctrl`

## Requirements
- R1: While reset is held, and on release, qacceptn and qacceptn_apb are 1, qdeny and qdeny_apb are 0, and sr_req is 0.
- R2: A main request (qreqn falling while geardown_mode is 0) raises sr_req. qacceptn stays 1 for as long as sr_ack remains 0.
- R3: One clk edge after sr_ack is seen high with sr_req raised, qacceptn falls to 0. sr_req stays 1 while the channel is stopped.
- R4: When qreqn rises in the stopped state, sr_req drops to 0. qacceptn stays 0 until sr_ack returns to 0, and rises to 1 one clk edge after that.
- R5: A main request that arrives while geardown_mode is 1 gets qdeny=1, with qacceptn staying 1 and sr_req staying 0. qdeny holds at 1 until qreqn returns to 1, and then drops to 0.
- R6: qdeny_apb is 0 at all times.
- R7: While apb_busy is 1, a register-bus request is not accepted. One pclk edge after apb_busy goes to 0, qacceptn_apb falls to 0.
- R8: When qreqn_apb rises while the register-bus channel is stopped, qacceptn_apb returns to 1 without waiting on any other input.
- R9: qactive is 1 whenever any of these holds: mem_pending is 1; the channel is stopped while sr_ack is 0; or apb_busy, synchronised into clk, is 1.
- R10: qactive_apb is 1 whenever apb_busy is 1. It is also 1 when mem_pending, registered in clk and synchronised into pclk, is 1.
- R11: Each request input crosses a two-flop synchroniser. The response appears on the third edge of the channel's clock after the input changes, and not before.
- R12: The register-bus handshake accepts requests normally while geardown_mode is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main controller clock |
| rst | input | 1 | Synchronous active-high reset, clk domain |
| pclk | input | 1 | Register-bus clock |
| prst | input | 1 | Synchronous active-high reset, pclk domain |
| qreqn | input | 1 | Main quiescence request, active low |
| qacceptn | output | 1 | Main accept, active low |
| qdeny | output | 1 | Main refusal |
| qactive | output | 1 | Main clock wanted |
| qreqn_apb | input | 1 | Register-bus quiescence request, active low |
| qacceptn_apb | output | 1 | Register-bus accept, active low |
| qdeny_apb | output | 1 | Register-bus refusal (always 0) |
| qactive_apb | output | 1 | Register-bus clock wanted |
| geardown_mode | input | 1 | Gear-down configuration; refuses main requests |
| mem_pending | input | 1 | A memory transaction is waiting |
| sr_req | output | 1 | Ask the DRAM sequencer to enter self-refresh |
| sr_ack | input | 1 | DRAM is in self-refresh |
| apb_busy | input | 1 | Register-bus transfer in flight (pclk domain) |

## Verification
The main handshake is tried three ways. In the first, sr_ack is held back for several cycles, which shows whether acceptance really waits on self-refresh. In the second, gear-down is set during a request, which separates a refusal from an accept. In the third, exit is run with sr_ack still high, which shows whether the restart waits for the DRAM to leave self-refresh. The register-bus handshake is tried with the bus busy and with it idle, which tells postponement apart from refusal. Single-cycle probes at the second and third edge after a request pin down the synchroniser depth. Toggling mem_pending and apb_busy on their own shows that each one wakes the opposite channel.

// File: rtl/qlp_pkg.sv
package qlp_pkg;

    typedef enum logic [2:0] {
        MQ_RUN     = 3'd0,
        MQ_ENTER   = 3'd1,
        MQ_STOPPED = 3'd2,
        MQ_EXIT    = 3'd3,
        MQ_DENIED  = 3'd4
    } main_st_e;

    typedef enum logic [1:0] {
        AQ_RUN     = 2'd0,
        AQ_DRAIN   = 2'd1,
        AQ_STOPPED = 2'd2
    } apb_st_e;

    typedef struct packed {
        logic acceptn;
        logic deny;
        logic sr_req;
    } main_out_t;

    function automatic main_out_t main_decode(main_st_e st);
        main_out_t o;
        o.acceptn = !(st == MQ_STOPPED || st == MQ_EXIT);
        o.deny    = (st == MQ_DENIED);
        o.sr_req  = (st == MQ_ENTER || st == MQ_STOPPED);
        return o;
    endfunction

endpackage

// File: rtl/qlp_sync.sv
module qlp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_VAL;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/qlp_main_fsm.sv
module qlp_main_fsm
    import qlp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_n_s,
    input  logic geardown_mode,
    input  logic sr_ack,
    input  logic mem_pending,
    input  logic peer_wake_s,
    output logic acceptn,
    output logic deny,
    output logic active,
    output logic sr_req,
    output logic wake_out
);
    main_st_e  st_q, st_d;
    main_out_t dec;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MQ_RUN:     if (!req_n_s) st_d = geardown_mode ? MQ_DENIED : MQ_ENTER;
            MQ_ENTER:   if (sr_ack)   st_d = MQ_STOPPED;
            MQ_STOPPED: if (req_n_s)  st_d = MQ_EXIT;
            MQ_EXIT:    if (!sr_ack)  st_d = MQ_RUN;
            MQ_DENIED:  if (req_n_s)  st_d = MQ_RUN;
            default:                  st_d = MQ_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= MQ_RUN;
            wake_out <= 1'b0;
        end else begin
            st_q     <= st_d;
            wake_out <= mem_pending || (st_q == MQ_EXIT);
        end
    end

    assign dec     = main_decode(st_q);
    assign acceptn = dec.acceptn;
    assign deny    = dec.deny;
    assign sr_req  = dec.sr_req;
    assign active  = mem_pending || peer_wake_s || (st_q == MQ_STOPPED && !sr_ack);
endmodule

// File: rtl/qlp_apb_fsm.sv
module qlp_apb_fsm
    import qlp_pkg::*;
(
    input  logic pclk,
    input  logic prst,
    input  logic req_n_s,
    input  logic bus_busy,
    input  logic peer_wake_s,
    output logic acceptn,
    output logic active,
    output logic wake_out
);
    apb_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            AQ_RUN:     if (!req_n_s) st_d = bus_busy ? AQ_DRAIN : AQ_STOPPED;
            AQ_DRAIN:   if (!bus_busy) st_d = AQ_STOPPED;
            AQ_STOPPED: if (req_n_s)  st_d = AQ_RUN;
            default:                  st_d = AQ_RUN;
        endcase
    end

    always_ff @(posedge pclk) begin
        if (prst) begin
            st_q     <= AQ_RUN;
            wake_out <= 1'b0;
        end else begin
            st_q     <= st_d;
            wake_out <= bus_busy;
        end
    end

    assign acceptn = (st_q != AQ_STOPPED);
    assign active  = bus_busy || peer_wake_s;
endmodule

// File: rtl/dual_qchan_lp_ctrl.sv
module dual_qchan_lp_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pclk,
    input  logic prst,
    input  logic qreqn,
    output logic qacceptn,
    output logic qdeny,
    output logic qactive,
    input  logic qreqn_apb,
    output logic qacceptn_apb,
    output logic qdeny_apb,
    output logic qactive_apb,
    input  logic geardown_mode,
    input  logic mem_pending,
    output logic sr_req,
    input  logic sr_ack,
    input  logic apb_busy
);
    logic main_req_s, apb_req_s;
    logic main_wake, apb_wake;
    logic main_wake_p, apb_wake_m;

    qlp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_mreq (
        .clk(clk), .rst(rst), .d(qreqn), .q(main_req_s));
    qlp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_areq (
        .clk(pclk), .rst(prst), .d(qreqn_apb), .q(apb_req_s));
    qlp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_m2a (
        .clk(pclk), .rst(prst), .d(main_wake), .q(main_wake_p));
    qlp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_a2m (
        .clk(clk), .rst(rst), .d(apb_wake), .q(apb_wake_m));

    qlp_main_fsm i_main (
        .clk(clk), .rst(rst), .req_n_s(main_req_s),
        .geardown_mode(geardown_mode), .sr_ack(sr_ack),
        .mem_pending(mem_pending), .peer_wake_s(apb_wake_m),
        .acceptn(qacceptn), .deny(qdeny), .active(qactive),
        .sr_req(sr_req), .wake_out(main_wake));

    qlp_apb_fsm i_apb (
        .pclk(pclk), .prst(prst), .req_n_s(apb_req_s),
        .bus_busy(apb_busy), .peer_wake_s(main_wake_p),
        .acceptn(qacceptn_apb), .active(qactive_apb),
        .wake_out(apb_wake));

    assign qdeny_apb = 1'b0;
endmodule

// File: rtl/qlp_checker.sv
module qlp_checker (
    input logic clk,
    input logic rst,
    input logic pclk,
    input logic prst,
    input logic qacceptn,
    input logic qdeny,
    input logic qactive,
    input logic qacceptn_apb,
    input logic qactive_apb,
    input logic mem_pending,
    input logic sr_req,
    input logic sr_ack,
    input logic apb_busy
);
    assert_req_before_ack_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sr_req) |-> qacceptn);

    assert_accept_after_sr_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(qacceptn) |-> $past(sr_ack) && sr_req);

    assert_exit_after_sr_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(qacceptn) |-> !$past(sr_ack) && !sr_req);

    assert_deny_excl_R5: assert property (@(posedge clk) disable iff (rst)
        qdeny |-> qacceptn && !sr_req);

    assert_apb_idle_accept_R7: assert property (@(posedge pclk) disable iff (prst)
        $fell(qacceptn_apb) |-> !$past(apb_busy));

    assert_pending_wakes_R9: assert property (@(posedge clk) disable iff (rst)
        mem_pending |-> qactive);

    assert_busy_wakes_R10: assert property (@(posedge pclk) disable iff (prst)
        apb_busy |-> qactive_apb);
endmodule

bind dual_qchan_lp_ctrl qlp_checker i_qlp_checker (
    .clk(clk), .rst(rst), .pclk(pclk), .prst(prst),
    .qacceptn(qacceptn), .qdeny(qdeny), .qactive(qactive),
    .qacceptn_apb(qacceptn_apb), .qactive_apb(qactive_apb),
    .mem_pending(mem_pending), .sr_req(sr_req), .sr_ack(sr_ack),
    .apb_busy(apb_busy));

// File: tb/test_dual_qchan_lp_ctrl.sv
module test_dual_qchan_lp_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic qreqn = 1'b1, qreqn_apb = 1'b1;
    logic geardown_mode = 1'b0, mem_pending = 1'b0, sr_ack = 1'b0, apb_busy = 1'b0;
    logic qacceptn, qdeny, qactive, qacceptn_apb, qdeny_apb, qactive_apb, sr_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dual_qchan_lp_ctrl i_dual_qchan_lp_ctrl (
        .clk(clk), .rst(rst), .pclk(clk), .prst(rst),
        .qreqn(qreqn), .qacceptn(qacceptn), .qdeny(qdeny), .qactive(qactive),
        .qreqn_apb(qreqn_apb), .qacceptn_apb(qacceptn_apb),
        .qdeny_apb(qdeny_apb), .qactive_apb(qactive_apb),
        .geardown_mode(geardown_mode), .mem_pending(mem_pending),
        .sr_req(sr_req), .sr_ack(sr_ack), .apb_busy(apb_busy));

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        cyc(1);
        check("R1", "qacceptn in reset", qacceptn, 1'b1);
        check("R1", "qdeny in reset", qdeny, 1'b0);
        check("R1", "sr_req in reset", sr_req, 1'b0);
        rst = 1'b0;
        cyc(1);
        check("R1", "qacceptn_apb after reset", qacceptn_apb, 1'b1);
        check("R1", "qdeny_apb after reset", qdeny_apb, 1'b0);
    endtask

    task automatic t_main_cycle;
        qreqn = 1'b0;
        cyc(3);
        check("R2", "sr_req raised", sr_req, 1'b1);
        cyc(5);
        check("R2", "qacceptn held without sr_ack", qacceptn, 1'b1);
        sr_ack = 1'b1;
        cyc(1);
        check("R3", "qacceptn falls after sr_ack", qacceptn, 1'b0);
        check("R3", "sr_req held while stopped", sr_req, 1'b1);
        check("R9", "qactive quiet in self-refresh", qactive, 1'b0);
        sr_ack = 1'b0;
        #1;
        check("R9", "qactive when stopped out of self-refresh", qactive, 1'b1);
        sr_ack = 1'b1;
        cyc(1);
        qreqn = 1'b1;
        cyc(3);
        check("R4", "sr_req dropped on exit", sr_req, 1'b0);
        check("R4", "qacceptn low while sr_ack high", qacceptn, 1'b0);
        cyc(4);
        check("R4", "qacceptn still low", qacceptn, 1'b0);
        sr_ack = 1'b0;
        cyc(1);
        check("R4", "qacceptn back high", qacceptn, 1'b1);
    endtask

    task automatic t_geardown;
        geardown_mode = 1'b1;
        qreqn = 1'b0;
        cyc(3);
        check("R5", "qdeny raised", qdeny, 1'b1);
        check("R5", "no sr_req on deny", sr_req, 1'b0);
        check("R5", "qacceptn stays high", qacceptn, 1'b1);
        cyc(5);
        check("R5", "qdeny held", qdeny, 1'b1);
        qreqn = 1'b1;
        cyc(2);
        check("R5", "qdeny held until sync", qdeny, 1'b1);
        cyc(1);
        check("R5", "qdeny released", qdeny, 1'b0);
    endtask

    task automatic t_apb_geardown;
        qreqn_apb = 1'b0;
        cyc(2);
        check("R11", "no accept at second edge", qacceptn_apb, 1'b1);
        cyc(1);
        check("R11", "accept at third edge", qacceptn_apb, 1'b0);
        check("R12", "apb accepted in gear-down", qacceptn_apb, 1'b0);
        check("R6", "qdeny_apb low", qdeny_apb, 1'b0);
        qreqn_apb = 1'b1;
        cyc(3);
        check("R8", "qacceptn_apb released", qacceptn_apb, 1'b1);
        geardown_mode = 1'b0;
    endtask

    task automatic t_apb_busy;
        apb_busy = 1'b1;
        qreqn_apb = 1'b0;
        cyc(8);
        check("R7", "accept postponed while busy", qacceptn_apb, 1'b1);
        check("R6", "no deny while busy", qdeny_apb, 1'b0);
        apb_busy = 1'b0;
        cyc(1);
        check("R7", "accept after bus idle", qacceptn_apb, 1'b0);
        qreqn_apb = 1'b1;
        cyc(3);
        check("R8", "apb exit immediate", qacceptn_apb, 1'b1);
    endtask

    task automatic t_cross_wake;
        cyc(4);
        check("R9", "qactive idle", qactive, 1'b0);
        check("R10", "qactive_apb idle", qactive_apb, 1'b0);
        mem_pending = 1'b1;
        #1;
        check("R9", "qactive on pending", qactive, 1'b1);
        cyc(4);
        check("R10", "qactive_apb woken by pending", qactive_apb, 1'b1);
        mem_pending = 1'b0;
        cyc(5);
        check("R10", "qactive_apb drops", qactive_apb, 1'b0);
        apb_busy = 1'b1;
        #1;
        check("R10", "qactive_apb on busy", qactive_apb, 1'b1);
        cyc(4);
        check("R9", "qactive woken by apb_busy", qactive, 1'b1);
        apb_busy = 1'b0;
        cyc(5);
        check("R9", "qactive drops", qactive, 1'b0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        cyc(3);
        t_reset();
        t_main_cycle();
        t_geardown();
        t_apb_geardown();
        t_apb_busy();
        t_cross_wake();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule